// File: doc/BRIEF.md
# Self-Aligned Two-Bank Instruction Fetch

This block hands the decoder a complete group of instructions on every accepted fetch, whatever the position of the fetch address inside a cache line. Lines alternate between two interleaved storage banks, so the line holding the fetch address and the line after it always sit in different banks. Both banks are read in the same cycle. The two lines are then joined, and the group is taken from the joined pair starting at the word offset of the address. Because the second line is always there, an address near the end of a line still yields the full group.

Each word in the group passes through a small predecoder that marks control transfers, meaning jumps, branches, calls and returns. The group is cut after the first such word. Words up to and including that transfer are marked valid, and every word after it is marked invalid. The block also returns the sequential address at which fetching continues: the address just past the group, or the address just past the transfer when the group was cut. Addresses count instruction words. The banks are synchronous arrays owned by the surrounding logic. The block drives their read enables and indices and consumes their line data one cycle later. Its own outputs are registered, so a result appears two clock edges after its request, and it accepts a new request every cycle.

Top module: `selfaligned_fetch`

## Requirements
- R1: While reset is asserted and until the first request has travelled through, outValid is 0, outMask is 0 and outNextPc is 0.
- R2: With line number L = reqPc / 4, line L is in bank 0 at index L/2 when L is even and in bank 1 at index L/2 when L is odd. For a request, the bank holding line L receives that index and the other bank receives the index of line (L+1) modulo the number of lines, in the same cycle.
- R3: A request presented with reqValid at one rising edge produces outValid high right after the second rising edge that follows. Back-to-back requests give back-to-back results, and each cycle without a request gives one cycle with outValid low.
- R4: Slot i of outSlots, at bits [32*i+31 : 32*i], holds the instruction word at address (reqPc + i) modulo 2^PC_W. This holds for every word offset, including a group that runs from the last line into line 0.
- R5: A word is a control transfer exactly when its two top bits [31:30] are 2'b11.
- R6: outMask bit 0 is always 1 for a result. Bit i is 1 exactly when none of slots 0 to i-1 is a control transfer, so the transfer itself stays valid.
- R7: outNextPc is reqPc + 4 when no slot is a control transfer. When the first transfer is in slot k, it is reqPc + k + 1. Both are taken modulo 2^PC_W.
- R8: Whenever outValid is 0, outMask is 0.
- R9: Both bank read enables are high in a cycle with reqValid and low in a cycle without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A fetch request is present this cycle |
| reqPc | input | PC_W | Fetch address in instruction words |
| bank0Rd | output | 1 | Read enable of the even-line bank |
| bank0Addr | output | PC_W-3 | Line index into the even-line bank |
| bank0Data | input | 4*INSN_W | Even-line bank data, one cycle after the read |
| bank1Rd | output | 1 | Read enable of the odd-line bank |
| bank1Addr | output | PC_W-3 | Line index into the odd-line bank |
| bank1Data | input | 4*INSN_W | Odd-line bank data, one cycle after the read |
| outValid | output | 1 | The fetch group outputs carry a result |
| outSlots | output | 4*INSN_W | Fetch group, slot 0 in the low bits |
| outMask | output | 4 | Per-slot valid bits |
| outNextPc | output | PC_W | Sequential address to fetch next |

## Verification
The assertions make three assumptions about the inputs. reqValid is driven to a known 0 throughout reset. Each bank returns, one cycle after a read, the line at the index it was given. Bank data is never consulted in a cycle that follows no read. The bench models both banks as registered arrays whose words are computed from their addresses. It never asserts reqValid during reset, and it changes the control-transfer pattern of the stored words only after the pipeline has drained. The sweep covers every fetch address under six transfer patterns and inserts regular idle cycles between requests.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic captureReq;  // latch the request address into stage 1
    logic loadOut;     // load the aligned group into the output registers
    logic clearOut;    // drop the output valid mask
  } fetchStrobes_t;

  // Top two bits of a word that mark a control transfer.
  localparam logic [1:0] CTI_CLASS = 2'b11;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output fetch_pkg::fetchStrobes_t strobes,
  output logic                    bankRd,
  output logic                    outValid
);

  logic stage1Valid;
  logic outValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValidQ   <= 1'b0;
    end else begin
      stage1Valid <= reqValid;
      outValidQ   <= stage1Valid;
    end
  end

  always_comb begin
    strobes.captureReq = reqValid;
    strobes.loadOut    = stage1Valid;
    strobes.clearOut   = !stage1Valid;
  end

  assign bankRd   = reqValid;
  assign outValid = outValidQ;

  // R3: a result only ever follows a request by exactly two edges
  p_two_edge_latency_r3 : assert property (@(posedge clk) disable iff (!rstN)
    outValidQ |-> $past(reqValid, 2));

  // R3: an idle request slot yields an idle result slot
  p_idle_propagates_r3 : assert property (@(posedge clk) disable iff (!rstN)
    !stage1Valid |=> !outValidQ);

endmodule

// File: rtl/fetch_align.sv
module fetch_align #(
  parameter  int INSN_W    = 32,
  parameter  int SLOTS     = 4,
  localparam int OFF_W     = $clog2(SLOTS),
  localparam int LINE_BITS = SLOTS * INSN_W
) (
  input  logic [OFF_W-1:0]     offset,
  input  logic                 oddLine,
  input  logic [LINE_BITS-1:0] bank0Data,
  input  logic [LINE_BITS-1:0] bank1Data,
  output logic [LINE_BITS-1:0] aligned
);

  logic [LINE_BITS-1:0]   curLine;
  logic [LINE_BITS-1:0]   nxtLine;
  logic [2*LINE_BITS-1:0] joined;

  // The first line comes from the bank matching its parity, the second from the other.
  always_comb begin
    curLine = oddLine ? bank1Data : bank0Data;
    nxtLine = oddLine ? bank0Data : bank1Data;
    joined  = {nxtLine, curLine};
  end

  always_comb begin
    aligned = '0;
    for (int i = 0; i < SLOTS; i++) begin
      aligned[i*INSN_W +: INSN_W] = joined[(int'(offset) + i)*INSN_W +: INSN_W];
    end
  end

endmodule

// File: rtl/fetch_truncate.sv
module fetch_truncate #(
  parameter  int INSN_W    = 32,
  parameter  int SLOTS     = 4,
  localparam int OFF_W     = $clog2(SLOTS),
  localparam int LINE_BITS = SLOTS * INSN_W
) (
  input  logic [LINE_BITS-1:0] slots,
  output logic [SLOTS-1:0]     groupMask,
  output logic [OFF_W:0]       groupLen
);

  import fetch_pkg::*;

  logic [SLOTS-1:0] isCti;

  // Per-slot predecode
  for (genvar g = 0; g < SLOTS; g++) begin : g_predecode
    assign isCti[g] = (slots[g*INSN_W + INSN_W - 2 +: 2] == CTI_CLASS);
  end

  // A slot survives while no earlier slot transfers control.
  always_comb begin
    groupMask[0] = 1'b1;
    for (int i = 1; i < SLOTS; i++) begin
      groupMask[i] = groupMask[i-1] & ~isCti[i-1];
    end
  end

  always_comb begin
    groupLen = '0;
    for (int i = 0; i < SLOTS; i++) begin
      groupLen = groupLen + (OFF_W+1)'(groupMask[i]);
    end
  end

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath #(
  parameter  int PC_W      = 8,
  parameter  int INSN_W    = 32,
  parameter  int SLOTS     = 4,
  localparam int OFF_W     = $clog2(SLOTS),
  localparam int LINE_W    = PC_W - OFF_W,
  localparam int BANK_AW   = LINE_W - 1,
  localparam int LINE_BITS = SLOTS * INSN_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fetch_pkg::fetchStrobes_t strobes,
  input  logic [PC_W-1:0]          reqPc,
  output logic [BANK_AW-1:0]       bank0Addr,
  output logic [BANK_AW-1:0]       bank1Addr,
  input  logic [LINE_BITS-1:0]     bank0Data,
  input  logic [LINE_BITS-1:0]     bank1Data,
  output logic [LINE_BITS-1:0]     outSlots,
  output logic [SLOTS-1:0]         outMask,
  output logic [PC_W-1:0]          outNextPc
);

  import fetch_pkg::*;

  logic [LINE_W-1:0]    reqLine;
  logic [LINE_W-1:0]    followLine;
  logic [PC_W-1:0]      s1Pc;
  logic [LINE_BITS-1:0] alignedSlots;
  logic [SLOTS-1:0]     groupMask;
  logic [OFF_W:0]       groupLen;
  logic [LINE_BITS-1:0] outSlotsQ;
  logic [SLOTS-1:0]     outMaskQ;
  logic [PC_W-1:0]      outNextPcQ;

  // Bank index generation: the following line always falls in the other bank.
  always_comb begin
    reqLine    = reqPc[PC_W-1:OFF_W];
    followLine = reqLine + LINE_W'(1);
    if (reqLine[0]) begin
      bank1Addr = reqLine[LINE_W-1:1];
      bank0Addr = followLine[LINE_W-1:1];
    end else begin
      bank0Addr = reqLine[LINE_W-1:1];
      bank1Addr = followLine[LINE_W-1:1];
    end
  end

  // Stage 1 holds the address while the banks return their lines.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Pc <= '0;
    end else if (strobes.captureReq) begin
      s1Pc <= reqPc;
    end
  end

  fetch_align #(
    .INSN_W (INSN_W),
    .SLOTS  (SLOTS)
  ) i_align (
    .offset    (s1Pc[OFF_W-1:0]),
    .oddLine   (s1Pc[OFF_W]),
    .bank0Data (bank0Data),
    .bank1Data (bank1Data),
    .aligned   (alignedSlots)
  );

  fetch_truncate #(
    .INSN_W (INSN_W),
    .SLOTS  (SLOTS)
  ) i_truncate (
    .slots     (alignedSlots),
    .groupMask (groupMask),
    .groupLen  (groupLen)
  );

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSlotsQ  <= '0;
      outMaskQ   <= '0;
      outNextPcQ <= '0;
    end else if (strobes.loadOut) begin
      outSlotsQ  <= alignedSlots;
      outMaskQ   <= groupMask;
      outNextPcQ <= s1Pc + PC_W'(groupLen);
    end else if (strobes.clearOut) begin
      outMaskQ   <= '0;
    end
  end

  assign outSlots  = outSlotsQ;
  assign outMask   = outMaskQ;
  assign outNextPc = outNextPcQ;

  // R2: the two bank indices always name adjacent lines
  p_bank_pair_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (bank0Addr == bank1Addr) || (bank0Addr == bank1Addr + BANK_AW'(1)));

  for (genvar g = 0; g < SLOTS - 1; g++) begin : g_mask_checks
    // R6: valid slots form a prefix
    p_mask_prefix_r6 : assert property (@(posedge clk) disable iff (!rstN)
      outMaskQ[g+1] |-> outMaskQ[g]);
    // R5 R6: no valid slot follows a transfer
    p_cti_cuts_r6 : assert property (@(posedge clk) disable iff (!rstN)
      outMaskQ[g+1] |-> (outSlotsQ[g*INSN_W + INSN_W - 2 +: 2] != CTI_CLASS));
    // R6: a valid non-transfer slot lets the group continue
    p_group_continues_r6 : assert property (@(posedge clk) disable iff (!rstN)
      (outMaskQ[g] && (outSlotsQ[g*INSN_W + INSN_W - 2 +: 2] != CTI_CLASS))
        |-> outMaskQ[g+1]);
  end

endmodule

// File: rtl/selfaligned_fetch.sv
module selfaligned_fetch #(
  parameter  int PC_W      = 8,
  parameter  int INSN_W    = 32,
  parameter  int SLOTS     = 4,
  localparam int OFF_W     = $clog2(SLOTS),
  localparam int BANK_AW   = PC_W - OFF_W - 1,
  localparam int LINE_BITS = SLOTS * INSN_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [PC_W-1:0]      reqPc,
  output logic                 bank0Rd,
  output logic [BANK_AW-1:0]   bank0Addr,
  input  logic [LINE_BITS-1:0] bank0Data,
  output logic                 bank1Rd,
  output logic [BANK_AW-1:0]   bank1Addr,
  input  logic [LINE_BITS-1:0] bank1Data,
  output logic                 outValid,
  output logic [LINE_BITS-1:0] outSlots,
  output logic [SLOTS-1:0]     outMask,
  output logic [PC_W-1:0]      outNextPc
);

  fetch_pkg::fetchStrobes_t strobes;
  logic bankRd;

  fetch_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .bankRd   (bankRd),
    .outValid (outValid)
  );

  fetch_datapath #(
    .PC_W   (PC_W),
    .INSN_W (INSN_W),
    .SLOTS  (SLOTS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqPc     (reqPc),
    .bank0Addr (bank0Addr),
    .bank1Addr (bank1Addr),
    .bank0Data (bank0Data),
    .bank1Data (bank1Data),
    .outSlots  (outSlots),
    .outMask   (outMask),
    .outNextPc (outNextPc)
  );

  assign bank0Rd = bankRd;
  assign bank1Rd = bankRd;

  // R8: an idle output carries no valid slot
  p_idle_mask_r8 : assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outMask == '0));

  // R6: a result always has slot 0
  p_slot0_valid_r6 : assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outMask[0]);

endmodule

// File: tb/test_selfaligned_fetch.sv
module test_selfaligned_fetch;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 8;
  localparam int INSN_W = 32;
  localparam int SLOTS  = 4;
  localparam int NLINES = 64;
  localparam int LBITS  = SLOTS * INSN_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [PC_W-1:0]  reqPc = '0;
  logic             bank0Rd, bank1Rd;
  logic [4:0]       bank0Addr, bank1Addr;
  logic [LBITS-1:0] bank0Data = '0;
  logic [LBITS-1:0] bank1Data = '0;
  logic             outValid;
  logic [LBITS-1:0] outSlots;
  logic [SLOTS-1:0] outMask;
  logic [PC_W-1:0]  outNextPc;

  int  tests = 0;
  int  fails = 0;
  int  pat = 0;
  bit  run = 1'b0;
  bit  done = 1'b0;

  logic            p0v = 1'b0, p1v = 1'b0;
  logic [PC_W-1:0] p0pc = '0, p1pc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfaligned_fetch i_selfaligned_fetch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPc(reqPc),
    .bank0Rd(bank0Rd), .bank0Addr(bank0Addr), .bank0Data(bank0Data),
    .bank1Rd(bank1Rd), .bank1Addr(bank1Addr), .bank1Data(bank1Data),
    .outValid(outValid), .outSlots(outSlots), .outMask(outMask), .outNextPc(outNextPc)
  );

  function automatic bit ctiAt(int a);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return (a % 3) == 2;
      3: return (a % 5) == 0;
      4: return (a & 3) == 3;
      default: return (((a * 13) >> 2) & 1) == 1;
    endcase
  endfunction

  // R5: transfer words carry 2'b11 in bits [31:30], others 2'b01
  function automatic logic [31:0] wordAt(int a);
    int w = a & 255;
    return {ctiAt(w) ? 2'b11 : 2'b01, 14'(pat), 16'(w)};
  endfunction

  function automatic logic [LBITS-1:0] lineAt(int line);
    logic [LBITS-1:0] l;
    for (int j = 0; j < SLOTS; j++) l[j*INSN_W +: INSN_W] = wordAt(line*SLOTS + j);
    return l;
  endfunction

  // Bank models: registered arrays, even lines in bank 0, odd lines in bank 1
  always @(posedge clk) begin
    if (bank0Rd) bank0Data <= lineAt(int'(bank0Addr) * 2);
    if (bank1Rd) bank1Data <= lineAt(int'(bank1Addr) * 2 + 1);
  end

  // Request history, two edges deep
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p0v <= 1'b0; p1v <= 1'b0; p0pc <= '0; p1pc <= '0;
    end else begin
      p1v <= p0v; p1pc <= p0pc;
      p0v <= reqValid; p0pc <= reqPc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LBITS-1:0] act, input logic [LBITS-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      int L, nx, e0, e1, cnt;
      logic [LBITS-1:0] eSlots;
      logic [SLOTS-1:0] eMask;
      bit stop;
      if (reqValid) begin
        L  = int'(reqPc) >> 2;
        nx = (L + 1) % NLINES;
        e0 = (L & 1) ? (nx >> 1) : (L >> 1);
        e1 = (L & 1) ? (L >> 1) : (nx >> 1);
        check(bank0Addr == 5'(e0), "R2", "bank0 index", LBITS'(bank0Addr), LBITS'(e0));
        check(bank1Addr == 5'(e1), "R2", "bank1 index", LBITS'(bank1Addr), LBITS'(e1));
        check(bank0Rd && bank1Rd, "R9", "read enables on request", LBITS'({bank0Rd, bank1Rd}), LBITS'(2'b11));
      end else begin
        check(!bank0Rd && !bank1Rd, "R9", "read enables idle", LBITS'({bank0Rd, bank1Rd}), '0);
      end
      check(outValid == p1v, "R3", "outValid timing", LBITS'(outValid), LBITS'(p1v));
      if (p1v) begin
        eSlots = '0; eMask = '0; stop = 1'b0; cnt = 0;
        for (int i = 0; i < SLOTS; i++) begin
          eSlots[i*INSN_W +: INSN_W] = wordAt(int'(p1pc) + i);
          if (!stop) begin eMask[i] = 1'b1; cnt++; end
          if (ctiAt((int'(p1pc) + i) & 255)) stop = 1'b1;
        end
        check(outSlots == eSlots, "R4", "aligned slots", outSlots, eSlots);
        check(outMask == eMask, "R5 R6", "valid mask", LBITS'(outMask), LBITS'(eMask));
        check(outNextPc == PC_W'(int'(p1pc) + cnt), "R7", "next pc",
              LBITS'(outNextPc), LBITS'(PC_W'(int'(p1pc) + cnt)));
      end else begin
        check(outMask == '0, "R8", "idle mask", LBITS'(outMask), '0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "reset valid", LBITS'(outValid), '0);
    check(outMask == '0, "R1", "reset mask", LBITS'(outMask), '0);
    check(outNextPc == '0, "R1", "reset next pc", LBITS'(outNextPc), '0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outMask == '0, "R1", "after reset", LBITS'({outValid, outMask}), '0);
    run = 1'b1;
    for (int p = 0; p < 6; p++) begin
      pat = p;
      for (int pc = 0; pc < 256; pc++) begin
        @(posedge clk); #1;
        reqValid = 1'b1; reqPc = PC_W'(pc);
        if (pc % 7 == 6) begin
          @(posedge clk); #1;
          reqValid = 1'b0;
        end
      end
      @(posedge clk); #1 reqValid = 1'b0;
      repeat (4) @(posedge clk);
      #1;
    end
    @(negedge clk);
    run = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule